// File: doc/BRIEF.md
# Fractional Audio Master-Clock and Bit-Clock Generator

This block produces the timing references for a serial audio port from a single fast system clock. For each of two independent directions, transmit and receive, it first runs a fractional rate generator. The generator adds a programmable step X to an accumulator on every system clock. Whenever the accumulator reaches the modulus Y, Y is subtracted and a pulse is emitted. Each pulse toggles a master-clock flop, so the master clock runs at `f_clk * X / Y / 2` with a 50% duty whenever the pulses are evenly spaced.

The master clock's rising edges are also issued as one-cycle strobes. An integer divider counts those strobes and issues a bit-clock strobe once every `D + 1` of them. Logic downstream runs on the system clock and uses the strobes as clock enables. The master-clock level reaches its output only while that direction's enable input is high.

A zero in either X or Y stops the clock. A modulus smaller than the step is handled as if the two were equal. Any change to a direction's rate word or bit divider restarts that direction from a clean state, so no shortened pulse is ever produced.

Top module: `aclk_gen`

## Requirements
- R1: With nonzero X and Y and Y >= X, a direction issues exactly X*K master-clock strobes in any window of 2*Y*K system clocks once running, and never issues strobes in two consecutive cycles.
- R2: When X or Y is zero, a direction issues no master-clock strobe and no bit-clock strobe, and its master-clock output stays low.
- R3: Each master-clock strobe coincides with a rising edge of the master-clock level. When Y is a multiple of X, the level is high for exactly half of any window of 2*Y*K clocks.
- R4: When Y < X, the direction behaves as if X equalled Y: one master-clock strobe every two system clocks.
- R5: The bit-clock strobe is issued once for every D+1 master-clock strobes and always in the cycle right after a master-clock strobe, where D is the 6-bit divider value.
- R6: The master-clock enable gates only the master-clock output pin. While it is low the pin stays low, and both strobes keep their rate.
- R7: In the cycle after any change of a direction's rate word or bit divider, that direction's master-clock level and both strobes are low, and the generator restarts from an empty accumulator.
- R8: In the 16-bit rate word, Y is held in bits 7:0 and X in bits 15:8.
- R9: The transmit and receive directions are fully independent. Configuring one never alters the rates of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock feeding both rate generators |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_rate | input | 16 | Transmit rate word: X in 15:8, Y in 7:0 |
| tx_bdiv | input | 6 | Transmit bit divider D (divide by D+1) |
| tx_mclk_en | input | 1 | Drive the transmit master clock onto its pin |
| rx_rate | input | 16 | Receive rate word: X in 15:8, Y in 7:0 |
| rx_bdiv | input | 6 | Receive bit divider D (divide by D+1) |
| rx_mclk_en | input | 1 | Drive the receive master clock onto its pin |
| tx_mclk | output | 1 | Transmit master-clock level, gated by its enable |
| tx_mclk_stb | output | 1 | One-cycle strobe on each transmit master-clock rise |
| tx_bclk_stb | output | 1 | One-cycle transmit bit-clock strobe |
| rx_mclk | output | 1 | Receive master-clock level, gated by its enable |
| rx_mclk_stb | output | 1 | One-cycle strobe on each receive master-clock rise |
| rx_bclk_stb | output | 1 | One-cycle receive bit-clock strobe |

## Verification
Some properties are checked on every cycle for both directions. Master-clock strobes never fall in back-to-back cycles. A zero step or modulus held for a few cycles silences both strobes. A rise of the enabled pin always carries a strobe. Every bit strobe follows a master strobe. Any configuration change leaves all outputs low one cycle later.

Other properties are long-run results that only the bench scenarios can show. These are the exact strobe counts over whole periods for fractional ratios, the half-high duty, the folding of Y < X, the field order in the rate word, and the independence of the two directions.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
    localparam int unsigned ACLK_STEP_W = 8;  // width of X and Y
    localparam int unsigned ACLK_BDIV_W = 6;  // width of bit divider
    localparam int unsigned ACLK_NCHAN  = 2;  // transmit and receive

    // Channel index meaning
    localparam int unsigned ACLK_CH_TX = 0;
    localparam int unsigned ACLK_CH_RX = 1;
endpackage

// File: rtl/aclk_frac_rate.sv
// Accumulator-based fractional pulse generator: pulse rate = X/Y per clock.
module aclk_frac_rate #(
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [STEP_W-1:0] step_x,
    input  logic [STEP_W-1:0] mod_y,
    output logic              pulse
);
    localparam int unsigned ACC_W = STEP_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             pulse;
    } frac_st_t;

    frac_st_t st_d, st_q;
    logic [STEP_W-1:0] x_eff;
    logic [ACC_W-1:0]  sum;

    always_comb begin
        st_d  = st_q;
        // A modulus below the step saturates to the full rate.
        x_eff = (mod_y < step_x) ? mod_y : step_x;
        sum   = st_q.acc + {1'b0, x_eff};
        if (clr || (step_x == '0) || (mod_y == '0)) begin
            st_d.acc   = '0;
            st_d.pulse = 1'b0;
        end else if (sum >= {1'b0, mod_y}) begin
            st_d.acc   = sum - {1'b0, mod_y};
            st_d.pulse = 1'b1;
        end else begin
            st_d.acc   = sum;
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/aclk_halver.sv
// Toggle stage: halves the pulse rate into a level and a rise strobe.
module aclk_halver (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic pulse,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic level;
        logic rise;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (clr) begin
            st_d.level = 1'b0;
        end else if (pulse) begin
            st_d.level = ~st_q.level;
            st_d.rise  = ~st_q.level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;
    assign rise  = st_q.rise;
endmodule

// File: rtl/aclk_bitdiv.sv
// Integer divider on master-clock rise strobes: one output per DIV+1 ticks.
module aclk_bitdiv #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             stb;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt == div) begin
                st_d.cnt = '0;
                st_d.stb = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stb = st_q.stb;
endmodule

// File: rtl/aclk_channel.sv
// One direction: change detector, fractional stage, halver, bit divider.
module aclk_channel #(
    parameter int unsigned STEP_W = 8,
    parameter int unsigned DIV_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*STEP_W-1:0] rate,
    input  logic [DIV_W-1:0]    bdiv,
    input  logic                mclk_en,
    output logic                mclk_pin,
    output logic                mclk_stb,
    output logic                bclk_stb
);
    localparam int unsigned CFG_W = 2*STEP_W + DIV_W;

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic              cfg_chg;
    logic [STEP_W-1:0] step_x, mod_y;
    logic              frac_pulse, level, rise;

    // Modulus in the low field, step in the high field.
    assign mod_y  = rate[STEP_W-1:0];
    assign step_x = rate[2*STEP_W-1:STEP_W];

    always_comb begin
        st_d     = st_q;
        st_d.cfg = {rate, bdiv};
        cfg_chg  = ({rate, bdiv} != st_q.cfg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    aclk_frac_rate #(.STEP_W(STEP_W)) u_frac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cfg_chg),
        .step_x (step_x),
        .mod_y  (mod_y),
        .pulse  (frac_pulse)
    );

    aclk_halver u_half (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_chg),
        .pulse (frac_pulse),
        .level (level),
        .rise  (rise)
    );

    aclk_bitdiv #(.DIV_W(DIV_W)) u_bdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_chg),
        .tick  (rise),
        .div   (bdiv),
        .stb   (bclk_stb)
    );

    assign mclk_pin = level & mclk_en;
    assign mclk_stb = rise;
endmodule

// File: rtl/aclk_gen.sv
module aclk_gen
    import aclk_pkg::*;
#(
    parameter int unsigned STEP_W = ACLK_STEP_W,
    parameter int unsigned DIV_W  = ACLK_BDIV_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*STEP_W-1:0] tx_rate,
    input  logic [DIV_W-1:0]    tx_bdiv,
    input  logic                tx_mclk_en,
    input  logic [2*STEP_W-1:0] rx_rate,
    input  logic [DIV_W-1:0]    rx_bdiv,
    input  logic                rx_mclk_en,
    output logic                tx_mclk,
    output logic                tx_mclk_stb,
    output logic                tx_bclk_stb,
    output logic                rx_mclk,
    output logic                rx_mclk_stb,
    output logic                rx_bclk_stb
);
    localparam int unsigned RATE_W = 2*STEP_W;

    logic [ACLK_NCHAN-1:0][RATE_W-1:0] rate_a;
    logic [ACLK_NCHAN-1:0][DIV_W-1:0]  bdiv_a;
    logic [ACLK_NCHAN-1:0]             en_a, pin_a, mstb_a, bstb_a;

    assign rate_a[ACLK_CH_TX] = tx_rate;
    assign rate_a[ACLK_CH_RX] = rx_rate;
    assign bdiv_a[ACLK_CH_TX] = tx_bdiv;
    assign bdiv_a[ACLK_CH_RX] = rx_bdiv;
    assign en_a[ACLK_CH_TX]   = tx_mclk_en;
    assign en_a[ACLK_CH_RX]   = rx_mclk_en;

    for (genvar c = 0; c < ACLK_NCHAN; c++) begin : g_chan
        aclk_channel #(.STEP_W(STEP_W), .DIV_W(DIV_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .rate     (rate_a[c]),
            .bdiv     (bdiv_a[c]),
            .mclk_en  (en_a[c]),
            .mclk_pin (pin_a[c]),
            .mclk_stb (mstb_a[c]),
            .bclk_stb (bstb_a[c])
        );
    end

    assign tx_mclk     = pin_a[ACLK_CH_TX];
    assign tx_mclk_stb = mstb_a[ACLK_CH_TX];
    assign tx_bclk_stb = bstb_a[ACLK_CH_TX];
    assign rx_mclk     = pin_a[ACLK_CH_RX];
    assign rx_mclk_stb = mstb_a[ACLK_CH_RX];
    assign rx_bclk_stb = bstb_a[ACLK_CH_RX];
endmodule

// File: rtl/aclk_gen_chk.sv
module aclk_gen_chk #(
    parameter int unsigned STEP_W = 8,
    parameter int unsigned DIV_W  = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*STEP_W-1:0] tx_rate,
    input logic [DIV_W-1:0]    tx_bdiv,
    input logic                tx_mclk_en,
    input logic [2*STEP_W-1:0] rx_rate,
    input logic [DIV_W-1:0]    rx_bdiv,
    input logic                rx_mclk_en,
    input logic                tx_mclk,
    input logic                tx_mclk_stb,
    input logic                tx_bclk_stb,
    input logic                rx_mclk,
    input logic                rx_mclk_stb,
    input logic                rx_bclk_stb
);
    logic tx_zero, rx_zero;
    assign tx_zero = (tx_rate[STEP_W-1:0] == '0) || (tx_rate[2*STEP_W-1:STEP_W] == '0);
    assign rx_zero = (rx_rate[STEP_W-1:0] == '0) || (rx_rate[2*STEP_W-1:STEP_W] == '0);

    // R1: master strobes never back to back
    a_r1_tx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mclk_stb |=> !tx_mclk_stb);
    a_r1_rx_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mclk_stb |=> !rx_mclk_stb);

    // R2: a held zero step or modulus silences both strobes
    a_r2_tx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_zero && $past(tx_zero) && $past(tx_zero, 2) && $past(tx_zero, 3))
        |-> (!tx_mclk_stb && !tx_bclk_stb));
    a_r2_rx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_zero && $past(rx_zero) && $past(rx_zero, 2) && $past(rx_zero, 3))
        |-> (!rx_mclk_stb && !rx_bclk_stb));

    // R3: an enabled pin rises only together with its strobe
    a_r3_tx_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mclk_en && $past(tx_mclk_en) && $rose(tx_mclk)) |-> tx_mclk_stb);
    a_r3_rx_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mclk_en && $past(rx_mclk_en) && $rose(rx_mclk)) |-> rx_mclk_stb);

    // R5: a bit strobe follows a master strobe by one cycle
    a_r5_tx_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bclk_stb |-> $past(tx_mclk_stb));
    a_r5_rx_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bclk_stb |-> $past(rx_mclk_stb));

    // R7: configuration change clears the direction on the next cycle
    a_r7_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_rate != $past(tx_rate)) || (tx_bdiv != $past(tx_bdiv)))
        |=> (!tx_mclk && !tx_mclk_stb && !tx_bclk_stb));
    a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_rate != $past(rx_rate)) || (rx_bdiv != $past(rx_bdiv)))
        |=> (!rx_mclk && !rx_mclk_stb && !rx_bclk_stb));
endmodule

bind aclk_gen aclk_gen_chk #(.STEP_W(STEP_W), .DIV_W(DIV_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_rate     (tx_rate),
    .tx_bdiv     (tx_bdiv),
    .tx_mclk_en  (tx_mclk_en),
    .rx_rate     (rx_rate),
    .rx_bdiv     (rx_bdiv),
    .rx_mclk_en  (rx_mclk_en),
    .tx_mclk     (tx_mclk),
    .tx_mclk_stb (tx_mclk_stb),
    .tx_bclk_stb (tx_bclk_stb),
    .rx_mclk     (rx_mclk),
    .rx_mclk_stb (rx_mclk_stb),
    .rx_bclk_stb (rx_bclk_stb)
);

// File: tb/aclk_gen_tb_top.sv
`timescale 1ns/1ps
module aclk_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tx_rate = '0, rx_rate = '0;
    logic [5:0]  tx_bdiv = '0, rx_bdiv = '0;
    logic        tx_mclk_en = 1'b0, rx_mclk_en = 1'b0;
    logic        tx_mclk, tx_mclk_stb, tx_bclk_stb;
    logic        rx_mclk, rx_mclk_stb, rx_bclk_stb;

    int n_chk = 0, n_fail = 0;
    int t_rise, t_bclk, t_high, r_rise, r_bclk, r_high;
    bit done = 1'b0;

    always #5 clk = ~clk;

    aclk_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_rate(tx_rate), .tx_bdiv(tx_bdiv), .tx_mclk_en(tx_mclk_en),
        .rx_rate(rx_rate), .rx_bdiv(rx_bdiv), .rx_mclk_en(rx_mclk_en),
        .tx_mclk(tx_mclk), .tx_mclk_stb(tx_mclk_stb), .tx_bclk_stb(tx_bclk_stb),
        .rx_mclk(rx_mclk), .rx_mclk_stb(rx_mclk_stb), .rx_bclk_stb(rx_bclk_stb)
    );

    function automatic int exp_rises(int x, int y, int w);
        int xe;
        if (x == 0 || y == 0) return 0;
        xe = (x > y) ? y : x;
        return (w * xe) / (2 * y);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_tx(int x, int y, int d, bit en);
        tx_rate = {x[7:0], y[7:0]};
        tx_bdiv = d[5:0];
        tx_mclk_en = en;
    endtask

    task automatic set_rx(int x, int y, int d, bit en);
        rx_rate = {x[7:0], y[7:0]};
        rx_bdiv = d[5:0];
        rx_mclk_en = en;
    endtask

    // Called at a negedge: settle, then count outputs over w cycles
    task automatic run_window(int w);
        repeat (6) @(negedge clk);
        t_rise = 0; t_bclk = 0; t_high = 0;
        r_rise = 0; r_bclk = 0; r_high = 0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            t_rise += int'(tx_mclk_stb); t_bclk += int'(tx_bclk_stb);
            t_high += int'(tx_mclk);
            r_rise += int'(rx_mclk_stb); r_bclk += int'(rx_bclk_stb);
            r_high += int'(rx_mclk);
        end
    endtask

    // Full TX check for one configuration
    task automatic tx_case(string req, int x, int y, int d, bit en, int k);
        int ye, w, er;
        @(negedge clk);
        set_tx(x, y, d, en);
        ye = (y == 0) ? 1 : y;
        w = 2 * ye * (d + 1) * k;
        run_window(w);
        er = exp_rises(x, y, w);
        check({req, " tx mclk strobes"}, t_rise, er);
        check({req, " tx bclk strobes (R5)"}, t_bclk, er / (d + 1));
        if (er == 0 || !en)
            check({req, " tx pin high cycles (R2/R6)"}, t_high, 0);
        else if (y % ((x > y) ? y : x) == 0)
            check({req, " tx duty (R3)"}, t_high, w / 2);
    endtask

    initial begin
        int x, y, d, seed;
        bit en;
        seed = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        // Reset state
        check("R2 reset tx_mclk", int'(tx_mclk), 0);
        check("R2 reset strobes", int'(tx_mclk_stb | tx_bclk_stb | rx_mclk_stb | rx_bclk_stb), 0);
        rst_n = 1'b1;
        set_rx(1, 1, 0, 1'b1);

        // R1/R3 fractional ratios, R8 field order (x=3,y=8 vs swapped)
        tx_case("R1 x3y8", 3, 8, 2, 1'b1, 2);
        tx_case("R8 x8y3 folds", 8, 3, 0, 1'b1, 2);
        tx_case("R1 x1y1", 1, 1, 0, 1'b1, 4);
        tx_case("R3 x2y6", 2, 6, 1, 1'b1, 2);
        // R4: Y below X gives the top rate
        tx_case("R4 x40y7", 40, 7, 3, 1'b1, 2);
        // R2: zero fields
        tx_case("R2 x0", 0, 9, 1, 1'b1, 2);
        tx_case("R2 y0", 5, 0, 1, 1'b1, 8);
        // R6: pin gated, strobes keep rate
        tx_case("R6 en off", 1, 4, 1, 1'b0, 2);
        // Full scale
        tx_case("R5 full scale", 1, 255, 63, 1'b1, 1);
        // R9: RX (x=y=1,d=0) kept running meanwhile
        check("R9 rx rate undisturbed", r_rise, 255 * 64);
        check("R9 rx bclk undisturbed", r_bclk, 255 * 64);

        // R7: change divider just after a rise; level must drop next cycle
        @(negedge clk);
        set_tx(1, 4, 0, 1'b1);
        repeat (6) @(negedge clk);
        while (!tx_mclk_stb) @(negedge clk);
        check("R7 pin high before change", int'(tx_mclk), 1);
        tx_bdiv = 6'd3;
        @(negedge clk);
        check("R7 pin cleared", int'(tx_mclk), 0);
        check("R7 strobes cleared", int'(tx_mclk_stb | tx_bclk_stb), 0);

        // R9: swap roles, RX configured, TX fixed
        @(negedge clk);
        set_tx(1, 1, 0, 1'b1);
        set_rx(5, 12, 2, 1'b1);
        run_window(2 * 12 * 3 * 2);
        check("R9 rx strobes", r_rise, exp_rises(5, 12, 144));
        check("R9 rx bclk", r_bclk, exp_rises(5, 12, 144) / 3);
        check("R9 tx strobes", t_rise, 72);

        // Random configurations
        for (int n = 0; n < 40; n++) begin
            x = $urandom_range(0, 45);
            y = $urandom_range(1, 40);
            d = $urandom_range(0, 7);
            en = 1'($urandom_range(0, 1));
            tx_case("R1 random", x, y, d, en, 2);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule